// File: doc/BRIEF.md
# ECC Scrub Address Scheduler

This block decides when a memory controller should issue background scrub reads and which address each read covers. Control logic gives it a start pulse together with a trigger policy, a count, a read length in bytes, a full-memory flag and a 37-bit address window. The block checks these settings and reports through a one-bit initiated flag whether the scrub was accepted. While it runs, it produces read requests over a valid/ready handshake. ECC decoding, writeback and the DRAM access are handled downstream.

Two trigger policies are available. In periodic mode the requests are held apart by a programmed number of clock cycles. In idle mode a countdown runs only while the controller's command queue reports empty, and it restarts from its full value whenever the queue turns busy. The address moves forward by the read length after each accepted request. When the next address would pass the upper bound, it returns to the lower bound. That bound is either the programmed window or, with the full-memory flag set, the whole device from address zero to a parameterised top address.

Top module: `scrub_sched_top`

## Requirements
- R1: After reset, `busy_o`, `req_valid_o` and `initiated_o` are all 0.
- R2: A start pulse is accepted when the block is not busy. Starting one cycle later, `initiated_o` shows 1 only if all of these hold: the length is nonzero, the length's three lowest bits are zero, the count is nonzero, and, when `full_mem_i` is 0, the end address is nonzero and the start address is not above the end address. If `initiated_o` is 0, the engine stays idle. The flag keeps its value until the next accepted start.
- R3: In periodic mode (`mode_i` = 0), `req_valid_o` rises in the cycle after an accepted start. After each handshake it stays low for exactly `count_i` cycles and then rises again.
- R4: In idle mode (`mode_i` = 1), `req_valid_o` rises once `queue_empty_i` has been sampled high on `count_i` consecutive clock edges after the start or the last handshake. An edge that samples it low restarts the count.
- R5: With `full_mem_i` = 0, the first request uses the start address. Each handshake adds the length to the address. If the sum exceeds the end address, the next request uses the start address again.
- R6: With `full_mem_i` = 1, addressing starts at 0 and wraps at parameter `MEM_TOP`. The window inputs are ignored, including a start address above the end address.
- R7: While `req_valid_o` is 1 and `req_ready_i` is 0, the valid signal, the address and the length all hold. `req_len_o` equals the programmed length.
- R8: A stop pulse that arrives while no request is pending makes the block idle in the next cycle. A stop that arrives while a request is pending leaves that request standing until it is accepted, and the block then goes idle.
- R9: A start pulse while `busy_o` is 1 is ignored. Its settings take no effect and `initiated_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples all settings |
| mode_i | input | 1 | 0 = periodic trigger, 1 = idle trigger |
| count_i | input | 16 | Interval or idle count in cycles |
| len_i | input | 12 | Scrub read length in bytes |
| full_mem_i | input | 1 | 1 = scrub the whole device |
| win_start_i | input | 37 | Window lower address |
| win_end_i | input | 37 | Window upper address |
| stop_i | input | 1 | Halt request |
| queue_empty_i | input | 1 | Controller command queue is empty |
| req_valid_o | output | 1 | Scrub read request valid |
| req_ready_i | input | 1 | Request accepted by controller |
| req_addr_o | output | 37 | Scrub read address |
| req_len_o | output | 12 | Scrub read length in bytes |
| initiated_o | output | 1 | Last accepted start was valid |
| busy_o | output | 1 | Engine running |

## Verification
The bench checks the wrap point in both window mode and full-memory mode. A design with an off-by-one in the wrap compare would skip the end address or issue one request past it. It measures the exact gap after a handshake in both trigger modes, and in idle mode it drops `queue_empty_i` in the middle of a countdown. A counter that does not reload would fire early. Stops and new starts are fired at random points, including while a request is waiting for `req_ready_i`. A design that drops a pending request or accepts a second start would show the wrong valid signal or the wrong address. Each rejection condition for the settings is applied on its own, and a case with start above end is paired with the full-memory flag to show that the window is ignored there.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
   typedef enum logic {
      TRIG_PERIODIC = 1'b0,
      TRIG_IDLE     = 1'b1
   } trig_mode_e;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_WAIT  = 2'd1,
      ST_ISSUE = 2'd2
   } sched_st_e;
endpackage

// File: rtl/scrub_param_check.sv
module scrub_param_check #(
   parameter int ADDR_W     = 37,
   parameter int CNT_W      = 16,
   parameter int LEN_W      = 12,
   parameter int ALIGN_BITS = 3
) (
   input  logic [LEN_W-1:0]  len_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              full_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   output logic              ok_o
);
   logic len_ok;
   logic win_ok;

   generate
      if (ALIGN_BITS > 0) begin : g_align
         assign len_ok = (len_i[ALIGN_BITS-1:0] == '0) && (len_i != '0);
      end else begin : g_noalign
         assign len_ok = (len_i != '0);
      end
   endgenerate

   assign win_ok = full_i || ((hi_i != '0) && (lo_i <= hi_i));
   assign ok_o   = len_ok && win_ok && (count_i != '0);
endmodule

// File: rtl/scrub_trigger.sv
module scrub_trigger
   import scrub_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  trig_mode_e       mode_i,
   input  logic             run_i,
   input  logic             q_empty_i,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             hold_off;

   // idle policy: a busy queue pins the countdown at its full value
   assign hold_off = (mode_i == TRIG_IDLE) && !q_empty_i;
   assign fire_o   = run_i && !hold_off && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (run_i) begin
         if (hold_off)           cnt_q <= load_val_i;
         else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/scrub_addr_walker.sv
module scrub_addr_walker #(
   parameter int              ADDR_W  = 37,
   parameter int              LEN_W   = 12,
   parameter logic [ADDR_W-1:0] MEM_TOP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              full_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   input  logic              adv_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int AW1 = ADDR_W + 1;

   logic [ADDR_W-1:0] base_q, lim_q, addr_q;
   logic [AW1-1:0]    nxt;
   logic              past_end;

   assign nxt      = {1'b0, addr_q} + AW1'(len_i);
   assign past_end = nxt > {1'b0, lim_q};
   assign addr_o   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         lim_q  <= '0;
         addr_q <= '0;
      end else if (init_i) begin
         base_q <= full_i ? '0 : lo_i;
         lim_q  <= full_i ? MEM_TOP : hi_i;
         addr_q <= full_i ? '0 : lo_i;
      end else if (adv_i) begin
         addr_q <= past_end ? base_q : nxt[ADDR_W-1:0];
      end
   end
endmodule

// File: rtl/scrub_sched_top.sv
module scrub_sched_top
   import scrub_pkg::*;
#(
   parameter int                ADDR_W     = 37,
   parameter int                CNT_W      = 16,
   parameter int                LEN_W      = 12,
   parameter int                ALIGN_BITS = 3,
   parameter logic [ADDR_W-1:0] MEM_TOP    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              full_mem_i,
   input  logic [ADDR_W-1:0] win_start_i,
   input  logic [ADDR_W-1:0] win_end_i,
   input  logic              stop_i,
   input  logic              queue_empty_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [LEN_W-1:0]  req_len_o,
   output logic              initiated_o,
   output logic              busy_o
);
   generate
      if (ALIGN_BITS >= LEN_W) begin : g_bad_align
         $error("ALIGN_BITS must be below LEN_W");
      end
      if (LEN_W > ADDR_W) begin : g_bad_len
         $error("LEN_W must not exceed ADDR_W");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   sched_st_e        st_q;
   trig_mode_e       mode_q;
   logic [CNT_W-1:0] cnt_val_q;
   logic [LEN_W-1:0] len_q;
   logic             init_q, stop_pend_q;
   logic             params_ok, accept, hs, load, fire;
   logic [CNT_W-1:0] load_val;

   assign hs       = (st_q == ST_ISSUE) && req_ready_i;
   assign accept   = (st_q == ST_OFF) && start_i && params_ok;
   assign load     = accept || hs;
   assign load_val = accept ? count_i : cnt_val_q;

   scrub_param_check #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)
   ) u_check (
      .len_i(len_i), .count_i(count_i), .full_i(full_mem_i),
      .lo_i(win_start_i), .hi_i(win_end_i), .ok_o(params_ok)
   );

   scrub_trigger #(.CNT_W(CNT_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
      .mode_i(mode_q), .run_i(st_q == ST_WAIT), .q_empty_i(queue_empty_i),
      .fire_o(fire)
   );

   scrub_addr_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_TOP(MEM_TOP)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .init_i(accept), .full_i(full_mem_i),
      .lo_i(win_start_i), .hi_i(win_end_i), .adv_i(hs), .len_i(len_q),
      .addr_o(req_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_OFF;
         mode_q      <= TRIG_PERIODIC;
         cnt_val_q   <= '0;
         len_q       <= '0;
         init_q      <= 1'b0;
         stop_pend_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_OFF: begin
               stop_pend_q <= 1'b0;
               if (start_i) begin
                  init_q <= params_ok;
                  if (params_ok) begin
                     mode_q    <= trig_mode_e'(mode_i);
                     cnt_val_q <= count_i;
                     len_q     <= len_i;
                     st_q      <= mode_i ? ST_WAIT : ST_ISSUE;
                  end
               end
            end
            ST_WAIT: begin
               if (stop_i)    st_q <= ST_OFF;
               else if (fire) st_q <= ST_ISSUE;
            end
            ST_ISSUE: begin
               if (hs) begin
                  stop_pend_q <= 1'b0;
                  st_q        <= (stop_i || stop_pend_q) ? ST_OFF : ST_WAIT;
               end else if (stop_i) begin
                  stop_pend_q <= 1'b1;
               end
            end
            default: st_q <= ST_OFF;
         endcase
      end
   end

   assign req_valid_o = (st_q == ST_ISSUE);
   assign req_len_o   = len_q;
   assign initiated_o = init_q;
   assign busy_o      = (st_q != ST_OFF);
endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
   parameter int ADDR_W     = 37,
   parameter int LEN_W      = 12,
   parameter int ALIGN_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [LEN_W-1:0]  len_i,
   input logic              stop_i,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic [LEN_W-1:0]  req_len_o,
   input logic              initiated_o,
   input logic              busy_o
);
   localparam logic [LEN_W-1:0] LEN_MASK = LEN_W'((1 << ALIGN_BITS) - 1);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

   // R2
   bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i && ((len_i & LEN_MASK) != '0) |=> !initiated_o && !busy_o);

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(initiated_o));

   // R8
   stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !req_valid_o && stop_i |=> !busy_o);

   // R3
   drop_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && req_ready_i |=> !req_valid_o);

   // R1
   quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o);
endmodule

bind scrub_sched_top scrub_sched_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)
) u_sched_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .stop_i(stop_i),
   .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
   .req_len_o(req_len_o), .initiated_o(initiated_o), .busy_o(busy_o)
);

// File: tb/test_scrub_sched_top.sv
`timescale 1ns/1ps
module test_scrub_sched_top;
   localparam int              AW   = 37;
   localparam logic [AW-1:0]   MTOP = 37'h3FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 0, mode_i = 0, full_mem_i = 0, stop_i = 0;
   logic          queue_empty_i = 1, req_ready_i = 1;
   logic [15:0]   count_i = 0;
   logic [11:0]   len_i = 0;
   logic [AW-1:0] win_start_i = 0, win_end_i = 0;
   logic          req_valid_o, initiated_o, busy_o;
   logic [AW-1:0] req_addr_o;
   logic [11:0]   req_len_o;

   int checks = 0, failures = 0;
   bit chk_en = 0;

   always #10 clk = ~clk;

   scrub_sched_top #(.MEM_TOP(MTOP)) i_scrub_sched_top (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .count_i(count_i), .len_i(len_i), .full_mem_i(full_mem_i),
      .win_start_i(win_start_i), .win_end_i(win_end_i), .stop_i(stop_i),
      .queue_empty_i(queue_empty_i), .req_valid_o(req_valid_o),
      .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
      .initiated_o(initiated_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // R2 acceptance rule
   function automatic bit exp_ok(input logic [11:0] l, input logic [15:0] c, input logic f,
                                 input logic [AW-1:0] s, input logic [AW-1:0] e);
      if (l == 0 || l[2:0] != 0) return 0;
      if (c == 0) return 0;
      if (!f && (e == 0 || s > e)) return 0;
      return 1;
   endfunction

   // expected-behaviour model built from the requirements
   logic          m_busy, m_valid, m_init, m_pend, m_mode, m_full;
   int            m_left, m_n;
   logic [AW-1:0] m_base, m_lim, m_addr;
   logic [11:0]   m_len;
   logic [AW:0]   m_nxt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_valid = 0; m_init = 0; m_pend = 0; m_left = 0;
         m_mode = 0; m_full = 0; m_n = 0; m_len = 0;
         m_base = 0; m_lim = 0; m_addr = 0;
      end else if (!m_busy) begin
         if (start_i) begin
            m_init = exp_ok(len_i, count_i, full_mem_i, win_start_i, win_end_i);
            if (m_init) begin
               m_busy = 1; m_mode = mode_i; m_n = count_i; m_len = len_i;
               m_full = full_mem_i; m_pend = 0;
               m_base = full_mem_i ? '0 : win_start_i;
               m_lim  = full_mem_i ? MTOP : win_end_i;
               m_addr = m_base;
               if (!mode_i) m_valid = 1;
               else begin m_valid = 0; m_left = m_n; end
            end
         end
      end else if (m_valid) begin
         if (req_ready_i) begin
            m_nxt  = {1'b0, m_addr} + {{(AW-11){1'b0}}, m_len};
            m_addr = (m_nxt > {1'b0, m_lim}) ? m_base : m_nxt[AW-1:0];
            m_valid = 0;
            if (stop_i || m_pend) begin m_busy = 0; m_pend = 0; end
            else m_left = m_n;
         end else if (stop_i) m_pend = 1;
      end else begin
         if (stop_i) m_busy = 0;
         else if (m_mode && !queue_empty_i) m_left = m_n;
         else begin
            m_left--;
            if (m_left == 0) m_valid = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && chk_en) begin
         chk(req_valid_o == m_valid, m_mode ? "R4 valid" : "R3 valid", 64'(req_valid_o), 64'(m_valid));
         chk(busy_o == m_busy, "R8 busy", 64'(busy_o), 64'(m_busy));
         chk(initiated_o == m_init, "R2 initiated", 64'(initiated_o), 64'(m_init));
         if (m_valid && req_valid_o) begin
            chk(req_addr_o == m_addr, m_full ? "R6 addr" : "R5 addr", 64'(req_addr_o), 64'(m_addr));
            chk(req_len_o == m_len, "R7 len", 64'(req_len_o), 64'(m_len));
         end
      end
   end

   task automatic kick(input logic md, input logic [15:0] c, input logic [11:0] l,
                       input logic f, input logic [AW-1:0] s, input logic [AW-1:0] e);
      mode_i = md; count_i = c; len_i = l; full_mem_i = f; win_start_i = s; win_end_i = e;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic halt();
      req_ready_i = 1; stop_i = 1;
      @(negedge clk);
      stop_i = 0;
      for (int i = 0; i < 4 && busy_o; i++) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy_o && !req_valid_o && !initiated_o, "R1 reset", {busy_o, req_valid_o, initiated_o}, 0);
      chk_en = 1;

      // R2 rejections, one cause each
      kick(0, 4, 12'd12, 0, 37'h100, 37'h200);  idle_cycles(2);
      kick(0, 4, 12'd0,  0, 37'h100, 37'h200);  idle_cycles(2);
      kick(0, 0, 12'd16, 0, 37'h100, 37'h200);  idle_cycles(2);
      kick(1, 4, 12'd16, 0, 37'h300, 37'h200);  idle_cycles(2);
      kick(1, 4, 12'd16, 0, 37'h0,   37'h0);    idle_cycles(2);

      // R3 + R5 periodic window with wrap, always ready
      req_ready_i = 1;
      kick(0, 3, 12'd16, 0, 37'h100, 37'h130);
      idle_cycles(30);
      // R7 hold under backpressure, R9 start while busy
      req_ready_i = 0;
      idle_cycles(3);
      kick(1, 9, 12'd8, 1, 37'h0, 37'h8);
      idle_cycles(8);
      req_ready_i = 1;
      idle_cycles(6);
      // R8 stop while a request is pending
      req_ready_i = 0;
      idle_cycles(4);
      stop_i = 1; @(negedge clk); stop_i = 0;
      idle_cycles(3);
      req_ready_i = 1;
      idle_cycles(3);

      // R4 idle mode with queue busy in mid countdown
      kick(1, 4, 12'd32, 0, 37'h40, 37'h1000);
      idle_cycles(2);
      queue_empty_i = 0; idle_cycles(3);
      queue_empty_i = 1; idle_cycles(12);
      queue_empty_i = 0; idle_cycles(2);
      queue_empty_i = 1; idle_cycles(10);
      // R8 stop while waiting
      halt();

      // R6 full memory, start above end, wrap at top
      kick(0, 1, 12'h100, 1, 37'h500, 37'h20);
      idle_cycles(20);
      halt();

      // random scenarios
      for (int k = 0; k < 60; k++) begin
         logic          md, f;
         logic [15:0]   c;
         logic [11:0]   l;
         logic [AW-1:0] s, e;
         md = $urandom % 2;
         f  = ($urandom % 4) == 0;
         c  = 16'(($urandom % 9 == 0) ? 0 : 1 + $urandom % 5);
         l  = 12'(($urandom % 8 == 0) ? 12 : (1 + $urandom % 6) * 8);
         s  = AW'(($urandom % 64) * 8);
         e  = ($urandom % 6 == 0) ? s - 8 : s + AW'($urandom % 160);
         kick(md, c, l, f, s, e);
         for (int t = 0; t < 120; t++) begin
            req_ready_i   = ($urandom % 3) != 0;
            queue_empty_i = ($urandom % 5) != 0;
            stop_i        = ($urandom % 70) == 0;
            start_i       = ($urandom % 50) == 0;
            @(negedge clk);
            stop_i = 0; start_i = 0;
         end
         halt();
         queue_empty_i = 1;
      end

      idle_cycles(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule